// File: doc/BRIEF.md
# Parallel Port Interrupt Handshake Controller

This block is a register-mapped parallel I/O peripheral. It has two 8-bit bidirectional ports, A and B. Each port has a data latch and a direction register. Each side also has two control lines. The first line of a side is always an input and sets a flag on a chosen edge. The second line of a side is either an edge-sensing input or an output, depending on a 3-bit mode field in the control register.

Flags are collected in a flag register and masked by an enable register. Together they drive an active-low interrupt request. A processor reaches the block over a narrow bus made of a 4-bit register select, a chip select and a read/not-write strobe. Every access is qualified by a slow-bus clock enable. Accessing a port data register has side effects: it clears that side's flags, and on side A it also drives the output handshake. A second address for port A data reads and writes the same latch with none of these side effects.

Control lines are sampled on a separate, faster clock enable. All outputs are registered. The reset is synchronous and active high.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, `rdata_oe` is 0, every port and second-line output enable is 0, and the direction, control, flag and enable registers read as 0x00 (the enable register reads as 0x80, see R9).
- R2: The register map is: select 0 is port B data, 1 is port A data (side effects), 2 is port B direction, 3 is port A direction, 0xC is control, 0xD is flags, 0xE is enables, and 0xF is port A data (no side effects). A direction bit of 1 makes that pin an output, so `x_pin_oe` equals the direction register and `x_pin_o` equals the data latch. A data read returns the latch bit for output pins and the pin input for input pins.
- R3: An access happens only on a clock where both `bus_en` and `cs` are 1. Read data appears on `rdata` after that edge, with `rdata_oe` set to 1. `rdata` and `rdata_oe` change only on `bus_en` cycles, and `rdata_oe` is 0 after a non-read bus cycle.
- R4: Control bit 0 selects the active edge of `a_edge_i` (1 = rising, 0 = falling) and sets flag bit 1. Control bit 4 does the same for `b_edge_i` and sets flag bit 4. The inactive edge sets nothing.
- R5: When the top bit of a second-line mode is 0, that line is an input. Mode bit 1 selects the edge (0 = falling, 1 = rising). The A second line sets flag bit 0 and the B second line sets flag bit 3. The A mode is control bits 3:1 and the B mode is control bits 7:5.
- R6: Any access to select 1 clears flag bit 1 and also clears flag bit 0, unless the A mode is 001 or 011 (independent). Select 0 does the same for flag bits 4 and 3 under the B mode.
- R7: Reads and writes at select 0xF clear no flag and leave `a_aux_o` unchanged.
- R8: Writing the flag register clears each flag whose written bit is 1 and leaves the others.
- R9: A write to the enable register with bit 7 = 1 sets the enables marked by 1s in bits 6:0, and with bit 7 = 0 clears them. Reading the enable register returns bit 7 as 1.
- R10: Flag register bit 7 reads 1, and `irq_n` goes to 0, exactly when some flag and its enable are both 1. A flag whose enable is 0 leaves `irq_n` at 1.
- R11: In mode 100 the second line is an output. It goes low on an access to that side's data register (select 1 for A, select 0 for B) and returns high on the next active first-line edge.
- R12: In mode 101 the A second line goes low on an access to select 1 and returns high at the next `bus_en` cycle without such an access.
- R13: Mode 110 drives the second line low and mode 111 drives it high. Modes with top bit 1 set its output enable to 1, and modes with top bit 0 set it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Slow-bus cycle enable; qualifies register accesses |
| samp_en | input | 1 | Fast enable for sampling control lines |
| cs | input | 1 | Chip select |
| rnw | input | 1 | 1 = read, 0 = write |
| sel | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data valid / bus drive enable |
| irq_n | output | 1 | Active-low interrupt request |
| a_edge_i | input | 1 | Side A first control line |
| a_aux_i | input | 1 | Side A second control line, input |
| a_aux_o | output | 1 | Side A second control line, output |
| a_aux_oe | output | 1 | Side A second control line, output enable |
| a_pin_i | input | DW | Port A pin inputs |
| a_pin_o | output | DW | Port A pin outputs |
| a_pin_oe | output | DW | Port A per-bit output enables |
| b_edge_i | input | 1 | Side B first control line |
| b_aux_i | input | 1 | Side B second control line, input |
| b_aux_o | output | 1 | Side B second control line, output |
| b_aux_oe | output | 1 | Side B second control line, output enable |
| b_pin_i | input | DW | Port B pin inputs |
| b_pin_o | output | DW | Port B pin outputs |
| b_pin_oe | output | DW | Port B per-bit output enables |

## Verification
The hardest case to reach is the interaction between the independent second-line modes and data-register accesses. The bench first has to latch a second-line flag under one mode. Then, with that flag still pending, it accesses the data register and shows that only the first-line flag clears. The stimulus reprograms the control register between input edges, so each edge is judged under the intended polarity and mode. It also steps each control line back to an idle level under the inactive polarity, so that polarity changes never create spurious flags. The output handshake is driven the same way: a data access lowers the line, an inactive edge leaves it low, and only the following active edge releases it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Register select codes
  localparam logic [3:0] SEL_B_DATA = 4'h0;
  localparam logic [3:0] SEL_A_HS   = 4'h1;
  localparam logic [3:0] SEL_B_DIR  = 4'h2;
  localparam logic [3:0] SEL_A_DIR  = 4'h3;
  localparam logic [3:0] SEL_CTRL   = 4'hC;
  localparam logic [3:0] SEL_FLAG   = 4'hD;
  localparam logic [3:0] SEL_IEN    = 4'hE;
  localparam logic [3:0] SEL_A_NH   = 4'hF;

  // Flag bit positions
  localparam int FLG_A2 = 0;
  localparam int FLG_A1 = 1;
  localparam int FLG_B2 = 3;
  localparam int FLG_B1 = 4;
  localparam int FLG_W  = 7;

  // Second-line modes
  typedef enum logic [2:0] {
    L2_IN_FALL     = 3'b000,
    L2_IN_FALL_IND = 3'b001,
    L2_IN_RISE     = 3'b010,
    L2_IN_RISE_IND = 3'b011,
    L2_OUT_HSHK    = 3'b100,
    L2_OUT_PULSE   = 3'b101,
    L2_OUT_LOW     = 3'b110,
    L2_OUT_HIGH    = 3'b111
  } l2_mode_t;
endpackage

// File: rtl/pio_edge_det.sv
module pio_edge_det #(
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_en,
  input  logic [NL-1:0] line_i,
  input  logic [NL-1:0] rise_sel,
  input  logic [NL-1:0] arm,
  output logic [NL-1:0] edge_o
);
  for (genvar g = 0; g < NL; g++) begin : g_line
    logic s_now;
    logic s_old;
    always_ff @(posedge clk) begin
      if (rst) begin
        s_now <= 1'b0;
        s_old <= 1'b0;
      end else if (samp_en) begin
        s_now <= line_i[g];
        s_old <= s_now;
      end
    end
    assign edge_o[g] = samp_en & arm[g] & (s_now ^ s_old) & (s_now == rise_sel[g]);
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_data,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe,
  output logic [DW-1:0] rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o  <= '0;
      pin_oe <= '0;
    end else begin
      if (wr_data) pin_o  <= wdata;
      if (wr_dir)  pin_oe <= wdata;
    end
  end

  assign rd_val = (pin_o & pin_oe) | (pin_i & ~pin_oe);
endmodule

// File: rtl/pio_aux_out.sv
module pio_aux_out
  import pio_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bus_en,
  input  l2_mode_t mode,
  input  logic     data_acc,
  input  logic     line1_edge,
  output logic     aux_o,
  output logic     aux_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      aux_o  <= 1'b1;
      aux_oe <= 1'b0;
    end else begin
      aux_oe <= mode[2];
      case (mode)
        L2_OUT_HSHK: begin
          if (data_acc)        aux_o <= 1'b0;
          else if (line1_edge) aux_o <= 1'b1;
        end
        L2_OUT_PULSE: if (bus_en) aux_o <= ~data_acc;
        L2_OUT_LOW:   aux_o <= 1'b0;
        default:      aux_o <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          samp_en,
  input  logic          cs,
  input  logic          rnw,
  input  logic [3:0]    sel,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rdata_oe,
  output logic          irq_n,
  input  logic          a_edge_i,
  input  logic          a_aux_i,
  output logic          a_aux_o,
  output logic          a_aux_oe,
  input  logic [DW-1:0] a_pin_i,
  output logic [DW-1:0] a_pin_o,
  output logic [DW-1:0] a_pin_oe,
  input  logic          b_edge_i,
  input  logic          b_aux_i,
  output logic          b_aux_o,
  output logic          b_aux_oe,
  input  logic [DW-1:0] b_pin_i,
  output logic [DW-1:0] b_pin_o,
  output logic [DW-1:0] b_pin_oe
);
  localparam int NLINES = 4;

  logic acc, wr_acc, a_data_acc, b_data_acc;
  logic [7:0] pcr;
  logic [FLG_W-1:0] ier, ifr, ifr_nxt;
  logic [NLINES-1:0] edges;
  logic e_a2, e_a1, e_b1, e_b2;
  logic [DW-1:0] a_rd, b_rd;
  logic [7:0] rmux;
  l2_mode_t a_mode, b_mode;
  logic a_ind, b_ind;

  assign acc        = bus_en & cs;
  assign wr_acc     = acc & ~rnw;
  assign a_data_acc = acc & (sel == SEL_A_HS);
  assign b_data_acc = acc & (sel == SEL_B_DATA);

  assign a_mode = l2_mode_t'(pcr[3:1]);
  assign b_mode = l2_mode_t'(pcr[7:5]);
  assign a_ind  = ~a_mode[2] & a_mode[0];
  assign b_ind  = ~b_mode[2] & b_mode[0];

  // Control and enable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pcr <= '0;
      ier <= '0;
    end else if (wr_acc) begin
      if (sel == SEL_CTRL) pcr <= wdata;
      if (sel == SEL_IEN) begin
        if (wdata[7]) ier <= ier | wdata[FLG_W-1:0];
        else          ier <= ier & ~wdata[FLG_W-1:0];
      end
    end
  end

  // Line order: 0 = A second, 1 = A first, 2 = B first, 3 = B second
  pio_edge_det #(.NL(NLINES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (samp_en),
    .line_i   ({b_aux_i, b_edge_i, a_edge_i, a_aux_i}),
    .rise_sel ({b_mode[1], pcr[4], pcr[0], a_mode[1]}),
    .arm      ({~b_mode[2], 1'b1, 1'b1, ~a_mode[2]}),
    .edge_o   (edges)
  );
  assign e_a2 = edges[0];
  assign e_a1 = edges[1];
  assign e_b1 = edges[2];
  assign e_b2 = edges[3];

  // Flags: clears first, new edges win
  always_comb begin
    ifr_nxt = ifr;
    if (wr_acc && sel == SEL_FLAG) ifr_nxt = ifr_nxt & ~wdata[FLG_W-1:0];
    if (a_data_acc) begin
      ifr_nxt[FLG_A1] = 1'b0;
      if (!a_ind) ifr_nxt[FLG_A2] = 1'b0;
    end
    if (b_data_acc) begin
      ifr_nxt[FLG_B1] = 1'b0;
      if (!b_ind) ifr_nxt[FLG_B2] = 1'b0;
    end
    if (e_a2) ifr_nxt[FLG_A2] = 1'b1;
    if (e_a1) ifr_nxt[FLG_A1] = 1'b1;
    if (e_b2) ifr_nxt[FLG_B2] = 1'b1;
    if (e_b1) ifr_nxt[FLG_B1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ifr   <= '0;
      irq_n <= 1'b1;
    end else begin
      ifr   <= ifr_nxt;
      irq_n <= ~|(ifr & ier);
    end
  end

  pio_port #(.DW(DW)) u_port_a (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_acc & ((sel == SEL_A_HS) | (sel == SEL_A_NH))),
    .wr_dir  (wr_acc & (sel == SEL_A_DIR)),
    .wdata   (wdata[DW-1:0]),
    .pin_i   (a_pin_i),
    .pin_o   (a_pin_o),
    .pin_oe  (a_pin_oe),
    .rd_val  (a_rd)
  );

  pio_port #(.DW(DW)) u_port_b (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_acc & (sel == SEL_B_DATA)),
    .wr_dir  (wr_acc & (sel == SEL_B_DIR)),
    .wdata   (wdata[DW-1:0]),
    .pin_i   (b_pin_i),
    .pin_o   (b_pin_o),
    .pin_oe  (b_pin_oe),
    .rd_val  (b_rd)
  );

  pio_aux_out u_aux_a (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .mode       (a_mode),
    .data_acc   (a_data_acc),
    .line1_edge (e_a1),
    .aux_o      (a_aux_o),
    .aux_oe     (a_aux_oe)
  );

  pio_aux_out u_aux_b (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .mode       (b_mode),
    .data_acc   (b_data_acc),
    .line1_edge (e_b1),
    .aux_o      (b_aux_o),
    .aux_oe     (b_aux_oe)
  );

  // Read path
  always_comb begin
    case (sel)
      SEL_B_DATA:         rmux = 8'(b_rd);
      SEL_A_HS, SEL_A_NH: rmux = 8'(a_rd);
      SEL_B_DIR:          rmux = 8'(b_pin_oe);
      SEL_A_DIR:          rmux = 8'(a_pin_oe);
      SEL_CTRL:           rmux = pcr;
      SEL_FLAG:           rmux = {|(ifr & ier), ifr};
      SEL_IEN:            rmux = {1'b1, ier};
      default:            rmux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else if (bus_en) begin
      rdata_oe <= cs & rnw;
      if (cs && rnw) rdata <= rmux;
    end
  end
endmodule

// File: rtl/pio_irq_ctrl_chk.sv
module pio_irq_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_en,
  input logic          cs,
  input logic          rnw,
  input logic [3:0]    sel,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          rdata_oe,
  input logic          irq_n,
  input logic          a_aux_o,
  input logic [DW-1:0] a_pin_oe,
  input logic [DW-1:0] b_pin_oe,
  input logic [7:0]    pcr,
  input logic [6:0]    ifr,
  input logic [6:0]    ier,
  input logic          e_a1,
  input logic          e_a2
);
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> ($stable(rdata) && $stable(rdata_oe))); // R3

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |-> $past(bus_en && cs && rnw)); // R3

  AST_DIR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && cs) |=> ($stable(a_pin_oe) && $stable(b_pin_oe))); // R2

  AST_A1_FLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(ifr[1]) |-> $past(e_a1)); // R4

  AST_A2_FLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(ifr[0]) |-> $past(e_a2)); // R5

  AST_DATA_CLEARS_A1: assert property (@(posedge clk) disable iff (rst)
    (bus_en && cs && sel == 4'h1 && !e_a1) |=> !ifr[1]); // R6

  AST_ALIAS_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_en && cs && sel == 4'hF) |=> ((ifr & $past(ifr)) == $past(ifr))); // R7

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (bus_en && cs && !rnw && sel == 4'hD && wdata[1] && !e_a1) |=> !ifr[1]); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(ier == 7'd0) |-> irq_n); // R10

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (pcr[3:1] == 3'b101 && bus_en && !(cs && sel == 4'h1)) |=> a_aux_o); // R12

  AST_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(pcr[3:1] == 3'b110) |-> !a_aux_o); // R13
endmodule

bind pio_irq_ctrl pio_irq_ctrl_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_en   (bus_en),
  .cs       (cs),
  .rnw      (rnw),
  .sel      (sel),
  .wdata    (wdata),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .irq_n    (irq_n),
  .a_aux_o  (a_aux_o),
  .a_pin_oe (a_pin_oe),
  .b_pin_oe (b_pin_oe),
  .pcr      (pcr),
  .ifr      (ifr),
  .ier      (ier),
  .e_a1     (e_a1),
  .e_a2     (e_a2)
);

// File: tb/pio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pio_irq_ctrl_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0;
  logic samp_en = 1'b0;
  logic cs = 1'b0;
  logic rnw = 1'b1;
  logic [3:0] sel = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rdata_oe, irq_n;
  logic a_edge_i = 1'b0, a_aux_i = 1'b0, b_edge_i = 1'b0, b_aux_i = 1'b0;
  logic a_aux_o, a_aux_oe, b_aux_o, b_aux_oe;
  logic [DW-1:0] a_pin_i = '0, b_pin_i = '0;
  logic [DW-1:0] a_pin_o, a_pin_oe, b_pin_o, b_pin_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int phase = 0;

  always #2 clk = ~clk;

  // Bus enable every 4th cycle, sample enable every 2nd
  always @(negedge clk) begin
    phase   = (phase + 1) % 4;
    bus_en  = (phase == 3);
    samp_en = ~samp_en;
  end

  pio_irq_ctrl #(.DW(DW)) u_pio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_en(bus_en), .samp_en(samp_en),
    .cs(cs), .rnw(rnw), .sel(sel), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .irq_n(irq_n),
    .a_edge_i(a_edge_i), .a_aux_i(a_aux_i), .a_aux_o(a_aux_o), .a_aux_oe(a_aux_oe),
    .a_pin_i(a_pin_i), .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe),
    .b_edge_i(b_edge_i), .b_aux_i(b_aux_i), .b_aux_o(b_aux_o), .b_aux_oe(b_aux_oe),
    .b_pin_i(b_pin_i), .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic waitclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_cycle(input logic c, input logic r, input logic [3:0] s,
                           input logic [7:0] d);
    @(negedge clk);
    cs = c; rnw = r; sel = s; wdata = d;
    forever begin
      @(posedge clk);
      if (bus_en) break;
    end
    @(negedge clk);
    cs = 1'b0; rnw = 1'b1;
  endtask

  task automatic bus_wr(input logic [3:0] s, input logic [7:0] d);
    bus_cycle(1'b1, 1'b0, s, d);
  endtask

  task automatic bus_rd(input logic [3:0] s, output logic [7:0] d);
    bus_cycle(1'b1, 1'b1, s, 8'h00);
    d = rdata;
  endtask

  task automatic rd_chk(input logic [3:0] s, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus_rd(s, v);
    chk(v, exp, tag);
  endtask

  task automatic t_reset;
    chk({7'd0, irq_n}, 8'h01, "R1 irq_n idle");
    chk({7'd0, rdata_oe}, 8'h00, "R1 rdata_oe");
    chk(a_pin_oe, 8'h00, "R1 a_pin_oe");
    chk(b_pin_oe, 8'h00, "R1 b_pin_oe");
    chk({6'd0, a_aux_oe, b_aux_oe}, 8'h00, "R1 aux oe");
    rd_chk(4'h3, 8'h00, "R1 dir A");
    rd_chk(4'hC, 8'h00, "R1 ctrl");
    rd_chk(4'hD, 8'h00, "R1 flags");
    rd_chk(4'hE, 8'h80, "R9 enable reset read");
  endtask

  task automatic t_ports;
    bus_wr(4'h3, 8'hF0);
    bus_wr(4'hF, 8'hA5);
    waitclk(1);
    chk(a_pin_oe, 8'hF0, "R2 a_pin_oe");
    chk(a_pin_o, 8'hA5, "R2 a_pin_o");
    a_pin_i = 8'h3C;
    rd_chk(4'hF, 8'hAC, "R2 mixed read");
    chk({7'd0, rdata_oe}, 8'h01, "R3 rdata_oe on read");
    bus_wr(4'h2, 8'hFF);
    bus_wr(4'h0, 8'h5A);
    chk({7'd0, rdata_oe}, 8'h00, "R3 rdata_oe after write");
    rd_chk(4'h0, 8'h5A, "R2 port B readback");
    chk(b_pin_oe, 8'hFF, "R2 b_pin_oe");
    bus_cycle(1'b0, 1'b0, 4'h0, 8'h00);
    waitclk(2);
    chk(b_pin_o, 8'h5A, "R3 no access without cs");
  endtask

  task automatic t_line1;
    bus_wr(4'hE, 8'h92);
    bus_wr(4'hC, 8'h01);
    a_edge_i = 1'b1; waitclk(8);
    rd_chk(4'hD, 8'h82, "R4 A first-line rising");
    chk({7'd0, irq_n}, 8'h00, "R10 irq asserted");
    rd_chk(4'h1, 8'hAC, "R2 A data read");
    waitclk(3);
    rd_chk(4'hD, 8'h00, "R6 A data access clears");
    chk({7'd0, irq_n}, 8'h01, "R10 irq released");
    b_edge_i = 1'b1; waitclk(8);
    rd_chk(4'hD, 8'h00, "R4 B inactive edge");
    b_edge_i = 1'b0; waitclk(8);
    rd_chk(4'hD, 8'h90, "R4 B first-line falling");
    rd_chk(4'h0, 8'h5A, "R2 B data read");
    rd_chk(4'hD, 8'h00, "R6 B data access clears");
  endtask

  task automatic t_line2;
    bus_wr(4'hE, 8'h89);
    bus_wr(4'hC, 8'h05);
    a_aux_i = 1'b1; waitclk(8);
    rd_chk(4'hD, 8'h81, "R5 A second-line rising");
    rd_chk(4'hF, 8'hAC, "R7 alias read value");
    rd_chk(4'hD, 8'h81, "R7 alias keeps flag");
    rd_chk(4'h1, 8'hAC, "R6 A read");
    rd_chk(4'hD, 8'h00, "R6 A second-line cleared");
    bus_wr(4'hC, 8'h03);
    a_aux_i = 1'b0; waitclk(8);
    rd_chk(4'hD, 8'h81, "R5 A second-line falling");
    rd_chk(4'h1, 8'hAC, "R6 A read independent");
    rd_chk(4'hD, 8'h81, "R6 independent keeps flag");
    bus_wr(4'hD, 8'h01);
    rd_chk(4'hD, 8'h00, "R8 write-one clears");
    bus_wr(4'hC, 8'h61);
    b_aux_i = 1'b1; waitclk(8);
    rd_chk(4'hD, 8'h88, "R5 B second-line rising");
    rd_chk(4'h0, 8'h5A, "R6 B read independent");
    rd_chk(4'hD, 8'h88, "R6 B independent keeps flag");
    bus_wr(4'hD, 8'h08);
    rd_chk(4'hD, 8'h00, "R8 B flag cleared");
    bus_wr(4'hC, 8'h01);
    b_aux_i = 1'b0; waitclk(8);
    rd_chk(4'hD, 8'h88, "R5 B second-line falling");
    rd_chk(4'h0, 8'h5A, "R6 B read");
    rd_chk(4'hD, 8'h00, "R6 B second-line cleared");
  endtask

  task automatic t_enable;
    bus_wr(4'hE, 8'h7F);
    rd_chk(4'hE, 8'h80, "R9 clear all enables");
    a_edge_i = 1'b0; waitclk(8);
    a_edge_i = 1'b1; waitclk(8);
    rd_chk(4'hD, 8'h02, "R10 masked flag no bit7");
    chk({7'd0, irq_n}, 8'h01, "R10 masked irq");
    bus_wr(4'hE, 8'h82);
    waitclk(3);
    chk({7'd0, irq_n}, 8'h00, "R10 enable raises irq");
    rd_chk(4'hE, 8'h82, "R9 set enable");
    bus_wr(4'hE, 8'h02);
    waitclk(3);
    rd_chk(4'hE, 8'h80, "R9 clear enable");
    chk({7'd0, irq_n}, 8'h01, "R10 disable releases irq");
    bus_wr(4'hD, 8'h7F);
  endtask

  task automatic t_handshake;
    a_edge_i = 1'b0; waitclk(8);
    bus_wr(4'hC, 8'h09);
    waitclk(3);
    chk({6'd0, a_aux_oe, a_aux_o}, 8'h03, "R11 hshk idle high, driven");
    bus_wr(4'h1, 8'h11);
    chk({7'd0, a_aux_o}, 8'h00, "R11 low after access");
    waitclk(8);
    chk({7'd0, a_aux_o}, 8'h00, "R11 stays low");
    a_edge_i = 1'b1; waitclk(8);
    chk({7'd0, a_aux_o}, 8'h01, "R11 released by edge");
    bus_wr(4'hF, 8'h22);
    waitclk(2);
    chk({7'd0, a_aux_o}, 8'h01, "R7 alias no handshake");
    chk(a_pin_o, 8'h22, "R7 alias writes latch");
    bus_wr(4'hD, 8'h7F);
  endtask

  task automatic t_pulse;
    logic [7:0] v;
    bus_wr(4'hC, 8'h0B);
    waitclk(3);
    chk({7'd0, a_aux_o}, 8'h01, "R12 pulse idle");
    bus_rd(4'h1, v);
    chk({7'd0, a_aux_o}, 8'h00, "R12 pulse low");
    waitclk(6);
    chk({7'd0, a_aux_o}, 8'h01, "R12 pulse ends");
  endtask

  task automatic t_held;
    bus_wr(4'hC, 8'h0C); waitclk(3);
    chk({6'd0, a_aux_oe, a_aux_o}, 8'h02, "R13 A held low");
    bus_wr(4'hC, 8'h0E); waitclk(3);
    chk({6'd0, a_aux_oe, a_aux_o}, 8'h03, "R13 A held high");
    bus_wr(4'hC, 8'hC0); waitclk(3);
    chk({5'd0, a_aux_oe, b_aux_oe, b_aux_o}, 8'h02, "R13 B held low, A input");
    bus_wr(4'hC, 8'hE0); waitclk(3);
    chk({6'd0, b_aux_oe, b_aux_o}, 8'h03, "R13 B held high");
    bus_wr(4'hC, 8'h80); waitclk(3);
    bus_wr(4'h0, 8'h33);
    chk({7'd0, b_aux_o}, 8'h00, "R11 B hshk low");
    b_edge_i = 1'b1; waitclk(8);
    chk({7'd0, b_aux_o}, 8'h00, "R11 B inactive edge");
    b_edge_i = 1'b0; waitclk(8);
    chk({7'd0, b_aux_o}, 8'h01, "R11 B released");
  endtask

  initial begin
    waitclk(6);
    rst = 1'b0;
    waitclk(2);
    t_reset();
    t_ports();
    t_line1();
    t_line2();
    t_enable();
    t_handshake();
    t_pulse();
    t_held();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule